// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the routing configuration of an interrupt controller. Software reaches it through two memory-mapped locations. The first is a select register that holds an 8-bit index. The second is a data window that reads or writes the register that index names. Behind the window sit three things: a 4-bit identification register, a read-only version word, and a table with one 64-bit routing entry per interrupt pin. Each table entry is reached as two 32-bit halves.

Each routing entry packs these fields:

| Field | Bits |
|---|---|
| Vector | 7:0 |
| Delivery mode | 10:8 |
| Destination mode | 11 |
| Polarity | 13 |
| Remote-IRR | 14 |
| Trigger mode | 15 |
| Mask | 16 |
| Destination ID | 63:56 |

The whole table is exported as a flat vector for the pin servicing logic, which lives outside this block. That logic reports pending requests on `pend_i` and raises remote-IRR through `rirr_set_i`. When a table entry is rewritten while its pin has a request pending, the block returns a one-cycle re-evaluate strobe for that pin, so the servicing logic can route the request again with the new settings.

Top module: `intr_route_regfile`

## Requirements
- R1: After reset, every table entry reads 0x00010000 in its low half and 0 in its upper half (only the mask bit, bit 16, is set). After reset the select register reads 0 and `id_o` is 0.
- R2: Only the low 8 bits of `bus_addr` are decoded. Offset 0x00 is the select register, which reads back its 8-bit value zero-extended. Offset 0x10 is the data window. Any other offset reads 0, and a write to it changes nothing. Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`.
- R3: With select 0x01, the window reads (pin count − 1) in bits 23:16 and the `VERSION` parameter in bits 7:0, with all other bits 0. Writes at that index change nothing.
- R4: With select 0x00, a window write stores data bits 27:24 as the ID. The ID reads back in bits 27:24 and appears on `id_o`. With select 0x02, the window reads the same ID field, but writes there are ignored.
- R5: A select value s of 0x10 or above addresses table entry (s − 0x10) >> 1. An odd s addresses bits 63:32 of the entry and an even s addresses bits 31:0.
- R6: A write to a low half replaces bits 31:0 and forces remote-IRR (bit 14) to 0. A pulse on `rirr_set_i[p]` sets bit 14 of entry p.
- R7: A write to an upper half replaces bits 63:32 only. Bits 31:0, including remote-IRR, are kept.
- R8: A table access whose entry index is at or beyond the pin count is dropped on write and reads 0. Selects 0x03 to 0x0F also read 0 and ignore writes.
- R9: A write is accepted only when `bus_len` is 4 or 8, and only the 32 data bits are used. Any other length leaves all state unchanged. This holds for writes to the select register too.
- R10: In the cycle after an accepted write to the table entry of pin p, `reeval_o` has exactly bit p set if `pend_i[p]` was high at the write. Otherwise `reeval_o` is 0.
- R11: `table_o[64*p +: 64]` always equals the content of entry p, as read through the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address; only the low 8 bits are decoded |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| pend_i | input | NPINS | Pending request flags from the servicing logic |
| rirr_set_i | input | NPINS | Sets remote-IRR of an entry |
| id_o | output | 4 | Identification value |
| table_o | output | 64*NPINS | All routing entries, entry p at bits 64p+63:64p |
| reeval_o | output | NPINS | One-cycle strobe: re-service this pin |

## Verification
The main sweep covers every select value from 0x10 to 0xFF. It writes a different data pattern per select, computed from that select, so a mix-up between the two halves, between neighbouring entries, or between valid and dropped indices all give distinct read-back values. The same sweep runs with pending flags on every third pin, which separates a missing strobe, a strobe on the wrong pin, and a strobe that ignores the pending flag. Further patterns cover the following:
- the ID and arbitration indices written with different data;
- the version index written and then read;
- undecoded offsets, and an aliased address with high bits set;
- a sweep over lengths 0 to 15;
- remote-IRR set, then an upper-half write that must keep it, then a lower-half write that must clear it.

// File: rtl/irf_pkg.sv
package irf_pkg;
    // bus offsets within the decoded 8-bit window
    localparam logic [7:0] OFF_SEL   = 8'h00;
    localparam logic [7:0] OFF_WIN   = 8'h10;
    // select indices
    localparam logic [7:0] IDX_ID    = 8'h00;
    localparam logic [7:0] IDX_VER   = 8'h01;
    localparam logic [7:0] IDX_ARB   = 8'h02;
    localparam logic [7:0] TBL_BASE  = 8'h10;
    // entry field positions
    localparam int RIRR_BIT = 14;
    localparam int MASK_BIT = 16;
    localparam int ENTRY_W  = 64;
    localparam int HALF_W   = 32;

    typedef enum logic [1:0] {
        K_ID   = 2'd0,
        K_VER  = 2'd1,
        K_TBL  = 2'd2,
        K_NONE = 2'd3
    } sel_kind_e;
endpackage

// File: rtl/irf_sel_decode.sv
module irf_sel_decode
    import irf_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDXW  = $clog2(NPINS)
) (
    input  logic [7:0]      sel_i,
    output sel_kind_e       kind_o,
    output logic            hit_o,
    output logic            hi_o,
    output logic [IDXW-1:0] idx_o
);
    logic [7:0] raw;

    always_comb begin
        raw    = (sel_i - TBL_BASE) >> 1;
        hi_o   = sel_i[0];
        idx_o  = raw[IDXW-1:0];
        kind_o = K_NONE;
        if (sel_i == IDX_ID || sel_i == IDX_ARB) begin
            kind_o = K_ID;
        end else if (sel_i == IDX_VER) begin
            kind_o = K_VER;
        end else if (sel_i >= TBL_BASE) begin
            kind_o = K_TBL;
        end
        hit_o = (kind_o == K_TBL) && (raw < 8'(NPINS));
    end
endmodule

// File: rtl/irf_entry.sv
module irf_entry
    import irf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [HALF_W-1:0]   wdata_i,
    input  logic                rirr_set_i,
    output logic [ENTRY_W-1:0]  entry_o
);
    logic [ENTRY_W-1:0] entry_d, entry_q;

    always_comb begin
        entry_d = entry_q;
        if (wr_hi_i) begin
            entry_d[ENTRY_W-1:HALF_W] = wdata_i;
        end
        if (rirr_set_i) begin
            entry_d[RIRR_BIT] = 1'b1;
        end
        if (wr_lo_i) begin
            entry_d[HALF_W-1:0] = wdata_i;
            entry_d[RIRR_BIT]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q           <= '0;
            entry_q[MASK_BIT] <= 1'b1;
        end else begin
            entry_q <= entry_d;
        end
    end

    assign entry_o = entry_q;

    // R6: a low-half write leaves remote-IRR clear
    p_lo_clears_rirr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (entry_o[RIRR_BIT] == 1'b0));

    // R7: an upper-half write alone keeps the low half
    p_hi_keeps_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_lo_i && !rirr_set_i) |=> $stable(entry_o[HALF_W-1:0]));

    // R6: remote-IRR rises only on a set request
    p_rirr_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_o[RIRR_BIT]) |-> $past(rirr_set_i));
endmodule

// File: rtl/irf_read_mux.sv
module irf_read_mux
    import irf_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter int          IDXW    = $clog2(NPINS),
    parameter logic [7:0]  VERSION = 8'h11
) (
    input  sel_kind_e              kind_i,
    input  logic                   hit_i,
    input  logic                   hi_i,
    input  logic [IDXW-1:0]        idx_i,
    input  logic [3:0]             id_i,
    input  logic [NPINS*ENTRY_W-1:0] table_i,
    output logic [HALF_W-1:0]      data_o
);
    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    logic [ENTRY_W-1:0] ent;

    always_comb begin
        ent = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (idx_i == IDXW'(p)) begin
                ent = table_i[p*ENTRY_W +: ENTRY_W];
            end
        end
        data_o = '0;
        unique case (kind_i)
            K_ID:    data_o = {4'h0, id_i, 24'h0};
            K_VER:   data_o = {8'h0, MAX_PIN, 8'h0, VERSION};
            K_TBL:   if (hit_i) data_o = hi_i ? ent[ENTRY_W-1:HALF_W] : ent[HALF_W-1:0];
            default: data_o = '0;
        endcase
    end
endmodule

// File: rtl/intr_route_regfile.sv
module intr_route_regfile
    import irf_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter int         ADDR_W  = 12,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [3:0]               bus_len,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     bus_rvalid,
    input  logic [NPINS-1:0]         pend_i,
    input  logic [NPINS-1:0]         rirr_set_i,
    output logic [3:0]               id_o,
    output logic [NPINS*64-1:0]      table_o,
    output logic [NPINS-1:0]         reeval_o
);
    localparam int IDXW = $clog2(NPINS);

    typedef struct packed {
        logic [7:0]       sel;
        logic [3:0]       id;
        logic [31:0]      rdata;
        logic             rvalid;
        logic [NPINS-1:0] reeval;
    } state_t;

    state_t st_d, st_q;

    sel_kind_e        kind;
    logic             hit, hi;
    logic [IDXW-1:0]  idx;
    logic [31:0]      win_rdata;
    logic [7:0]       off;
    logic             len_ok, wr_ok, sel_wr, win_wr, tbl_wr;
    logic [NPINS-1:0] wr_lo, wr_hi;

    irf_sel_decode #(.NPINS(NPINS), .IDXW(IDXW)) u_dec (
        .sel_i  (st_q.sel),
        .kind_o (kind),
        .hit_o  (hit),
        .hi_o   (hi),
        .idx_o  (idx)
    );

    irf_read_mux #(.NPINS(NPINS), .IDXW(IDXW), .VERSION(VERSION)) u_rmux (
        .kind_i  (kind),
        .hit_i   (hit),
        .hi_i    (hi),
        .idx_i   (idx),
        .id_i    (st_q.id),
        .table_i (table_o),
        .data_o  (win_rdata)
    );

    always_comb begin
        off    = bus_addr[7:0];
        len_ok = (bus_len == 4'd4) || (bus_len == 4'd8);
        wr_ok  = bus_wr && len_ok;
        sel_wr = wr_ok && (off == OFF_SEL);
        win_wr = wr_ok && (off == OFF_WIN);
        tbl_wr = win_wr && hit;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign wr_lo[p] = tbl_wr && (idx == IDXW'(p)) && !hi;
        assign wr_hi[p] = tbl_wr && (idx == IDXW'(p)) && hi;

        irf_entry u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo_i    (wr_lo[p]),
            .wr_hi_i    (wr_hi[p]),
            .wdata_i    (bus_wdata),
            .rirr_set_i (rirr_set_i[p]),
            .entry_o    (table_o[p*ENTRY_W +: ENTRY_W])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_rd;
        st_d.reeval = (wr_lo | wr_hi) & pend_i;
        if (sel_wr) begin
            st_d.sel = bus_wdata[7:0];
        end
        if (win_wr && st_q.sel == IDX_ID) begin
            st_d.id = bus_wdata[27:24];
        end
        if (bus_rd) begin
            if (off == OFF_SEL) begin
                st_d.rdata = {24'h0, st_q.sel};
            end else if (off == OFF_WIN) begin
                st_d.rdata = win_rdata;
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign id_o       = st_q.id;
    assign reeval_o   = st_q.reeval;

    // R10: at most one pin strobed per write
    p_reeval_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reeval_o));

    // R10: a strobe needs an accepted write one cycle earlier
    p_reeval_after_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|reeval_o) |-> $past(bus_wr));

    // R2: read data valid one cycle after a read strobe
    p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R4: the ID only moves on a write
    p_id_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(id_o));

    // R9: a bad length leaves the ID and the table unchanged
    p_badlen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(bus_len == 4'd4 || bus_len == 4'd8) && rirr_set_i == '0)
        |=> ($stable(id_o) && $stable(table_o)));
endmodule

// File: tb/tb_intr_route_regfile.sv
module tb_intr_route_regfile;
    localparam int NPINS = 24;
    localparam logic [7:0] VER = 8'h11;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [3:0]         bus_len = 4'd4;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               bus_rvalid;
    logic [NPINS-1:0]   pend_i = '0, rirr_set_i = '0;
    logic [3:0]         id_o;
    logic [NPINS*64-1:0] table_o;
    logic [NPINS-1:0]   reeval_o;

    int errors = 0, checks = 0, cycles = 0;
    logic [NPINS-1:0] last_reeval;

    always #2.5 clk = ~clk;

    intr_route_regfile dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pend_i(pend_i),
        .rirr_set_i(rirr_set_i), .id_o(id_o), .table_o(table_o), .reeval_o(reeval_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] len, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_len = len; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_reeval = reeval_o;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        check("R2 rvalid", 64'(bus_rvalid), 64'd1);
    endtask

    task automatic rd_idx(input logic [7:0] s, output logic [31:0] d);
        wr(12'h000, 4'd4, {24'h0, s});
        rd(12'h010, d);
    endtask

    function automatic logic [31:0] lo_pat(input logic [7:0] s);
        return {s, ~s, s ^ 8'h5A, s ^ 8'h3C};
    endfunction
    function automatic logic [31:0] hi_pat(input logic [7:0] s);
        return {s ^ 8'hC3, s, ~s, s};
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] exp_lo, exp_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 id", 64'(id_o), 64'd0);
        rd(12'h000, d);
        check("R1 select", 64'(d), 64'd0);
        for (int p = 0; p < NPINS; p++) begin
            check("R1 export", table_o[p*64 +: 64], 64'h0000_0000_0001_0000);
        end
        rd_idx(8'h10, d); check("R1 lo", 64'(d), 64'h00010000);
        rd_idx(8'h11, d); check("R1 hi", 64'(d), 64'h0);
        rd_idx(8'h3E, d); check("R1 last lo", 64'(d), 64'h00010000);

        // R3 version, write ignored
        wr(12'h000, 4'd4, 32'h01);
        wr(12'h010, 4'd4, 32'hFFFF_FFFF);
        rd(12'h010, d);
        check("R3 version", 64'(d), 64'({8'h0, 8'(NPINS-1), 8'h0, VER}));

        // R4 ID and arbitration index
        wr(12'h000, 4'd4, 32'h00);
        wr(12'h010, 4'd4, 32'hF500_0000);
        check("R4 id_o", 64'(id_o), 64'h5);
        rd(12'h010, d); check("R4 id read", 64'(d), 64'h0500_0000);
        wr(12'h000, 4'd4, 32'h02);
        wr(12'h010, 4'd4, 32'h0A00_0000);
        check("R4 arb write ignored", 64'(id_o), 64'h5);
        rd(12'h010, d); check("R4 arb read", 64'(d), 64'h0500_0000);

        // R8 reserved selects
        for (int s = 3; s < 16; s++) begin
            wr(12'h000, 4'd4, 32'(s));
            wr(12'h010, 4'd4, 32'hFFFF_FFFF);
            rd(12'h010, d); check("R8 reserved", 64'(d), 64'h0);
        end
        check("R8 id untouched", 64'(id_o), 64'h5);

        // R5/R6/R7/R10 sweep over every table select with pending pattern
        for (int p = 0; p < NPINS; p++) pend_i[p] = (p % 3 == 0);
        for (int s = 16; s < 256; s++) begin
            int pin;
            logic [NPINS-1:0] exp_rv;
            pin = (s - 16) >> 1;
            wr(12'h000, 4'd4, 32'(s));
            wr(12'h010, (s % 2 == 0) ? 4'd4 : 4'd8, (s % 2 == 1) ? hi_pat(8'(s)) : lo_pat(8'(s)));
            exp_rv = '0;
            if (pin < NPINS && pend_i[pin]) exp_rv[pin] = 1'b1;
            check("R10 reeval", 64'(last_reeval), 64'(exp_rv));
        end
        for (int s = 16; s < 256; s++) begin
            int pin;
            pin = (s - 16) >> 1;
            rd_idx(8'(s), d);
            if (pin >= NPINS) check("R8 beyond table", 64'(d), 64'h0);
            else if (s % 2 == 1) check("R5 R7 hi", 64'(d), 64'(hi_pat(8'(s))));
            else check("R5 R6 lo", 64'(d), 64'(lo_pat(8'(s)) & ~32'h4000));
        end
        for (int p = 0; p < NPINS; p++) begin
            exp_lo = lo_pat(8'(16 + 2*p)) & ~32'h4000;
            exp_hi = hi_pat(8'(17 + 2*p));
            check("R11 export", table_o[p*64 +: 64], {exp_hi, exp_lo});
        end

        // R10 no strobe when not pending
        pend_i = '0;
        wr(12'h000, 4'd4, 32'h10);
        wr(12'h010, 4'd4, 32'h0);
        check("R10 not pending", 64'(last_reeval), 64'h0);

        // R6/R7 remote-IRR handling on pin 5
        @(negedge clk); rirr_set_i[5] = 1'b1;
        @(negedge clk); rirr_set_i[5] = 1'b0;
        exp_lo = lo_pat(8'h1A) & ~32'h4000;
        check("R6 rirr set export", 64'(table_o[5*64 +: 32]), 64'(exp_lo | 32'h4000));
        wr(12'h000, 4'd4, 32'h1B);
        wr(12'h010, 4'd4, 32'h1234_5678);
        rd_idx(8'h1A, d); check("R7 rirr kept", 64'(d), 64'(exp_lo | 32'h4000));
        rd_idx(8'h1B, d); check("R7 hi new", 64'(d), 64'h1234_5678);
        wr(12'h000, 4'd4, 32'h1A);
        wr(12'h010, 4'd4, 32'hFFFF_FFFF);
        rd(12'h010, d); check("R6 lo clears rirr", 64'(d), 64'hFFFF_BFFF);

        // R9 length filter on pin 1 low half
        wr(12'h000, 4'd4, 32'h12);
        wr(12'h010, 4'd4, 32'hAAAA_0000);
        for (int l = 0; l < 16; l++) begin
            if (l != 4 && l != 8) begin
                wr(12'h010, 4'(l), 32'h5555_5555);
                rd(12'h010, d); check("R9 bad length", 64'(d), 64'hAAAA_0000);
            end
        end
        wr(12'h010, 4'd8, 32'h0000_1111);
        rd(12'h010, d); check("R9 length 8", 64'(d), 64'h0000_1111);
        wr(12'h000, 4'd2, 32'h14);
        rd(12'h000, d); check("R9 select bad length", 64'(d), 64'h12);

        // R2 offset decode
        wr(12'h020, 4'd4, 32'h0000_0000);
        rd(12'h010, d); check("R2 other offset write", 64'(d), 64'h0000_1111);
        rd(12'h020, d); check("R2 other offset read", 64'(d), 64'h0);
        wr(12'h300, 4'd4, 32'h11);
        rd(12'h000, d); check("R2 alias select", 64'(d), 64'h11);
        rd(12'h710, d); check("R2 alias window", 64'(d), 64'(hi_pat(8'h11)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule